// File: doc/BRIEF.md
# Self-Test Access Port Controller

This block sits between a host bus and an external self-test connector. The host selects self-test space by setting the top bit of its address. While such an access is in progress, the remaining address bits flow straight through to the test pins. When the access ends, the last address is held on those pins until the next self-test access. On a self-test read, the data present on the test pins is passed unchanged onto the pod data bus. At all other times the bus output from this block is zero.

A small host-written register records which kind of module sits in the test socket. From that code the block drives at most one of three power-select controls, one for each supply pin position (24, 28 or 32). The relays that these controls operate are outside the block.

Top module: `stap_top`

## Requirements
- R1: `latch_en` is high in the same cycle, combinationally, exactly when `host_addr[ADDR_W-1]` is 1 and at least one of `host_rd` or `host_wr` is 1.
- R2: While `latch_en` is high, `test_addr` equals `host_addr[ADDR_W-2:0]` in the same cycle.
- R3: While `latch_en` is low, `test_addr` shows the low address bits sampled at the last rising edge at which `latch_en` was high. Accesses outside self-test space and address changes do not alter it.
- R4: `data_oe` is high exactly when `host_addr[ADDR_W-1]` is 1, `host_rd` is 1 and `host_wr` is 0. It is never high during a write, including when both strobes are asserted together, and never high outside self-test space.
- R5: `pod_data` equals `pin_data` while `data_oe` is high, and is all zeros otherwise.
- R6: When `type_we` is 1 at a rising edge, `pwr_sel` takes the decode of `type_wdata` at that edge. Code 0 sets bit 0 (pin 24), code 1 sets bit 1 (pin 28), and code 2 sets bit 2 (pin 32).
- R7: Type code 3 drives all `pwr_sel` bits to 0, and `pwr_sel` never has more than one bit set.
- R8: A synchronous active-high `rst` clears the held address to 0 and `pwr_sel` to 0.
- R9: `pwr_sel` changes only on a type write. Self-test reads and writes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | ADDR_W (24) | Host address; the top bit selects self-test space |
| host_rd | input | 1 | Host read strobe, active high |
| host_wr | input | 1 | Host write strobe, active high |
| pin_data | input | DATA_W (8) | Data read back from the test connector pins |
| type_we | input | 1 | Write enable for the module-type register |
| type_wdata | input | 2 | Module-type code to store |
| latch_en | output | 1 | Address latch enable (transparent while high) |
| data_oe | output | 1 | Test data output enable toward the pod bus |
| test_addr | output | ADDR_W-1 (23) | Address presented to the test pins |
| pod_data | output | DATA_W (8) | Gated test-pin data for the pod data bus |
| pwr_sel | output | 3 | One-hot power-select controls for pins 24, 28 and 32 |

## Verification
The bench uses the default build: a 24-bit address and an 8-bit data path. At this width the top address bit is the selector, and the 23 held bits are wide enough to show stale and fresh values apart under random addresses. A 2-bit type code lets every code, including the unused one, be written directly. Random mixes of reads, writes, simultaneous strobes and non-self-test traffic are run between directed type sweeps. This exercises the hold behaviour across long idle stretches and across address changes outside self-test space.

// File: rtl/stap_pkg.sv
package stap_pkg;
  localparam int unsigned NUM_PWR_PINS = 3;
  localparam int unsigned TYPE_W       = $clog2(NUM_PWR_PINS + 1);

  typedef enum logic [TYPE_W-1:0] {
    MOD_PIN24 = 2'd0,
    MOD_PIN28 = 2'd1,
    MOD_PIN32 = 2'd2,
    MOD_NONE  = 2'd3
  } mod_type_e;
endpackage

// File: rtl/stap_decode.sv
module stap_decode #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              space_sel,
  input  logic              rd,
  input  logic              wr,
  input  logic [DATA_W-1:0] pin_data,
  output logic              le,
  output logic              oe,
  output logic [DATA_W-1:0] bus_data
);
  logic rd_only;

  assign rd_only = rd & ~wr;
  assign le      = space_sel & (rd | wr);
  assign oe      = space_sel & rd_only;

  for (genvar b = 0; b < DATA_W; b++) begin : g_gate
    assign bus_data[b] = oe & pin_data[b];
  end

  assert_no_oe_on_write_R4: assert property (@(posedge clk) disable iff (rst)
    wr |-> !oe);
  assert_no_oe_outside_R4: assert property (@(posedge clk) disable iff (rst)
    !space_sel |-> !oe);
  assert_oe_implies_le_R1: assert property (@(posedge clk) disable iff (rst)
    oe |-> le);
  assert_bus_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !oe |-> (bus_data == '0));
endmodule

// File: rtl/stap_addr_hold.sv
module stap_addr_hold #(
  parameter int unsigned AW = 23
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          le,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_out
);
  logic [AW-1:0] held_q;

  always_ff @(posedge clk) begin
    if (rst)     held_q <= '0;
    else if (le) held_q <= addr_in;
  end

  assign addr_out = le ? addr_in : held_q;

  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (!le && $past(!le)) |-> $stable(addr_out));
  assert_hold_capture_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(le) && !le) |-> (addr_out == $past(addr_in)));
endmodule

// File: rtl/stap_pwr_sel.sv
module stap_pwr_sel
  import stap_pkg::*;
#(
  parameter int unsigned NPINS = NUM_PWR_PINS,
  parameter int unsigned CW    = TYPE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [CW-1:0] wdata,
  output logic [NPINS-1:0] sel
);
  logic [NPINS-1:0] sel_q;

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst)     sel_q[g] <= 1'b0;
      else if (we) sel_q[g] <= (wdata == CW'(g));
    end
  end

  assign sel = sel_q;

  assert_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel));
  assert_unused_code_R7: assert property (@(posedge clk) disable iff (rst)
    (we && (wdata == CW'(MOD_NONE))) |=> (sel == '0));
  assert_only_on_write_R9: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(sel));
endmodule

// File: rtl/stap_top.sv
module stap_top
  import stap_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       host_addr,
  input  logic                    host_rd,
  input  logic                    host_wr,
  input  logic [DATA_W-1:0]       pin_data,
  input  logic                    type_we,
  input  logic [TYPE_W-1:0]       type_wdata,
  output logic                    latch_en,
  output logic                    data_oe,
  output logic [ADDR_W-2:0]       test_addr,
  output logic [DATA_W-1:0]       pod_data,
  output logic [NUM_PWR_PINS-1:0] pwr_sel
);
  localparam int unsigned LOW_W = ADDR_W - 1;

  logic space_sel;
  assign space_sel = host_addr[ADDR_W-1];

  stap_decode #(.DATA_W(DATA_W)) u_decode (
    .clk      (clk),
    .rst      (rst),
    .space_sel(space_sel),
    .rd       (host_rd),
    .wr       (host_wr),
    .pin_data (pin_data),
    .le       (latch_en),
    .oe       (data_oe),
    .bus_data (pod_data)
  );

  stap_addr_hold #(.AW(LOW_W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .le      (latch_en),
    .addr_in (host_addr[LOW_W-1:0]),
    .addr_out(test_addr)
  );

  stap_pwr_sel #(.NPINS(NUM_PWR_PINS), .CW(TYPE_W)) u_pwr (
    .clk  (clk),
    .rst  (rst),
    .we   (type_we),
    .wdata(type_wdata),
    .sel  (pwr_sel)
  );

  assert_pass_through_R2: assert property (@(posedge clk) disable iff (rst)
    latch_en |-> (test_addr == host_addr[LOW_W-1:0]));
  assert_reset_clear_R8: assert property (@(posedge clk)
    $past(rst) |-> (pwr_sel == '0));
endmodule

// File: tb/tb_stap_top.sv
`timescale 1ns/1ps
module tb_stap_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [23:0] host_addr;
  logic        host_rd, host_wr;
  logic [7:0]  pin_data;
  logic        type_we;
  logic [1:0]  type_wdata;
  logic        latch_en, data_oe;
  logic [22:0] test_addr;
  logic [7:0]  pod_data;
  logic [2:0]  pwr_sel;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [22:0] m_hold;
  logic [2:0]  m_pwr;

  always #2.5 clk = ~clk;

  stap_top dut (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_rd(host_rd),
    .host_wr(host_wr), .pin_data(pin_data), .type_we(type_we),
    .type_wdata(type_wdata), .latch_en(latch_en), .data_oe(data_oe),
    .test_addr(test_addr), .pod_data(pod_data), .pwr_sel(pwr_sel)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic f_le(logic [23:0] a, logic r, logic w);
    return a[23] && (r || w);
  endfunction
  function automatic logic f_oe(logic [23:0] a, logic r, logic w);
    return a[23] && r && !w;
  endfunction
  function automatic logic [2:0] f_pwr(logic [1:0] c);
    case (c)
      2'd0: return 3'b001;
      2'd1: return 3'b010;
      2'd2: return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    logic le_e, oe_e;
    le_e = f_le(host_addr, host_rd, host_wr);
    oe_e = f_oe(host_addr, host_rd, host_wr);
    chk("R1 latch_en", 32'(latch_en), 32'(le_e));
    if (le_e) chk("R2 test_addr pass", 32'(test_addr), 32'(host_addr[22:0]));
    else      chk("R3 test_addr hold", 32'(test_addr), 32'(m_hold));
    chk("R4 data_oe", 32'(data_oe), 32'(oe_e));
    chk("R5 pod_data", 32'(pod_data), oe_e ? 32'(pin_data) : 32'd0);
    chk("R6 R7 R9 pwr_sel", 32'(pwr_sel), 32'(m_pwr));
  endtask

  // drive at negedge, check mid-phase, update model at next rising edge
  task automatic step(logic [23:0] a, logic r, logic w, logic [7:0] p,
                      logic twe, logic [1:0] tc);
    @(negedge clk);
    host_addr = a; host_rd = r; host_wr = w; pin_data = p;
    type_we = twe; type_wdata = tc;
    #1;
    check_all();
    @(posedge clk);
    if (f_le(a, r, w)) m_hold = a[22:0];
    if (twe) m_pwr = f_pwr(tc);
  endtask

  initial begin
    int unsigned sd;
    sd = $urandom(32'd1234);
    rst = 1'b1; host_addr = '0; host_rd = 0; host_wr = 0; pin_data = '0;
    type_we = 0; type_wdata = '0;
    m_hold = '0; m_pwr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R8 reset test_addr", 32'(test_addr), 32'd0);
    chk("R8 reset pwr_sel", 32'(pwr_sel), 32'd0);
    chk("R8 reset data_oe", 32'(data_oe), 32'd0);

    // R6 / R7: sweep every type code
    for (int c = 0; c < 4; c++) begin
      step(24'h0, 0, 0, 8'h00, 1'b1, 2'(c));
      step(24'h0, 0, 0, 8'h00, 1'b0, 2'd0);
    end
    step(24'h0, 0, 0, 8'h00, 1'b1, 2'd1);

    // R3: capture, then idle and outside-space traffic must not disturb
    step(24'h8ABCDE, 1, 0, 8'h5A, 1'b0, 2'd0);
    step(24'h8ABCDE, 1, 0, 8'h5A, 1'b0, 2'd0);
    step(24'h7FFFFF, 1, 0, 8'hFF, 1'b0, 2'd0);
    step(24'h123456, 0, 1, 8'h33, 1'b0, 2'd0);
    step(24'hFFFFFF, 0, 0, 8'h11, 1'b0, 2'd0);
    chk("R3 held after idle", 32'(test_addr), 32'h0ABCDE);

    // R4: both strobes -> write, no output enable
    step(24'h800001, 1, 1, 8'hA5, 1'b0, 2'd0);
    // R9: self-test write with type data toggling but no type write
    step(24'hC00002, 0, 1, 8'hA5, 1'b0, 2'd3);
    chk("R9 pwr_sel kept", 32'(pwr_sel), 32'b010);

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [23:0] a;
      logic r, w, twe;
      a = 24'($urandom());
      r = 1'($urandom());
      w = 1'($urandom());
      twe = ($urandom() % 6) == 0;
      step(a, r, w, 8'($urandom()), twe, 2'($urandom()));
    end

    // R7: unused code after a valid one clears all selects
    step(24'h0, 0, 0, 8'h00, 1'b1, 2'd2);
    step(24'h0, 0, 0, 8'h00, 1'b1, 2'd3);
    step(24'h0, 0, 0, 8'h00, 1'b0, 2'd0);
    chk("R7 unused code none", 32'(pwr_sel), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule